// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a station-management master for an external Ethernet PHY. Software sees two 32-bit registers on a simple register bus: a command register and a data register. The command word carries the opcode, the PHY address and the PHY register number. It also carries a start flag, which doubles as the busy indication. Setting that flag launches one Clause 22 frame on MDC/MDIO.

For a write, software first loads the 16-bit value into the data register. The value is captured when the command is accepted, so later writes to the data register do not change the frame already in flight. For a read, the PHY's 16 bits replace the data register contents by the time the busy flag drops. MDC comes from the system clock through a parameterised half-period divider and rests low between frames. A frame always runs for a fixed number of MDC periods, so busy clears even when no PHY answers. In that case the pull-up on MDIO makes a read return all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command and data registers read 0, MDC is low and the MDIO output enable is low.
- R2: A command write (word address 0) with bit 0 set while idle starts a frame. Bit 0 then reads 1 until the frame ends and 0 afterwards. The command register reads back the direction in bit 1 (1 = write, 0 = read), the register number in bits 8:4 and the PHY address in bits 16:12. A command write with bit 0 clear only updates these fields and starts nothing.
- R3: Each frame lasts 64 MDC periods, sent MSB first. The order is: 32 ones, start 01, opcode (01 write, 10 read), 5-bit PHY address, 5-bit register number, 2 turnaround bits, 16 data bits.
- R4: A write frame drives MDIO for all 64 bits, with turnaround 10. Its data field is the data register value at command acceptance, and data register writes made while busy do not alter it.
- R5: A read frame drives MDIO for bits 0 to 46 (first turnaround bit sent as 1) and releases it from bit 47, the second turnaround bit, to the end. It samples MDIO on each MDC rising edge of bits 48 to 63 and places the result in data register bits 15:0, with bits 31:16 zero, when busy clears.
- R6: A read that no PHY answers leaves 0xFFFF in the data register.
- R7: MDC has a period of 2*DIV_HALF system clocks with DIV_HALF clocks high, and MDC and the output enable are low whenever the block is idle.
- R8: Command writes while busy are ignored: the frame in flight and the command register fields keep their accepted values.
- R9: Busy clears 128*DIV_HALF system clocks after acceptance, whether or not a PHY responds.
- R10: Register reads are registered: bus_rdata holds the addressed register one clock after bus_re. Address 0 is the command register, address 1 the data register, and other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address (0 command, 1 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable (1 = drive) |
| mdio_i | input | 1 | MDIO pad input (pulled up externally) |

## Verification
The assertions watch a set of properties on every cycle. MDC and the output enable must rest low while idle, and MDC may only toggle during a frame. The accepted command fields must hold steady while busy. The pad must be driven throughout a write and released from the second turnaround bit of a read. The busy period must never exceed its fixed length. Bit-exact frame content is shown only by the bench scenarios: a PHY model records each bit at MDC rising edges and answers reads. The same applies to the capture of the data register at acceptance, the read result landing in the data register, the all-ones value from an absent PHY and the MDC phase lengths.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int PRE_LEN   = 32;
  localparam int RELEASE_IDX = 47;
  localparam int DATA_IDX    = 48;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic       is_wr;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = en && (cnt == LAST);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mdio_cmd_t        cmd,
  input  logic [15:0]      wdata,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(RELEASE_IDX);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_IDX);

  logic [FRAME_LEN-1:0] sreg;
  logic                 active;
  logic                 is_wr;
  logic [FRAME_LEN-1:0] frame_word;
  mdio_op_e             op;

  assign op = cmd.is_wr ? OP_WRITE : OP_READ;
  assign frame_word = {{PRE_LEN{1'b1}}, 2'b01, op, cmd.phy, cmd.regn,
                       (cmd.is_wr ? 2'b10 : 2'b11),
                       (cmd.is_wr ? wdata : 16'hFFFF)};

  assign mdio_o = sreg[FRAME_LEN-1];
  assign done   = active && fall_evt && (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '1;
      active  <= 1'b0;
      is_wr   <= 1'b0;
      mdio_oe <= 1'b0;
      bit_idx <= '0;
      rd_data <= '0;
    end else if (start) begin
      sreg    <= frame_word;
      active  <= 1'b1;
      is_wr   <= cmd.is_wr;
      mdio_oe <= 1'b1;
      bit_idx <= '0;
    end else if (active) begin
      if (rise_evt && !is_wr && (bit_idx >= DAT_IDX))
        rd_data <= {rd_data[14:0], mdio_i};
      if (fall_evt) begin
        if (bit_idx == LAST_IDX) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sreg    <= {sreg[FRAME_LEN-2:0], 1'b1};
          if (!is_wr && (bit_idx + 1'b1 == REL_IDX))
            mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);

  logic             busy_q;
  mdio_cmd_t        cmd_q;
  mdio_cmd_t        cmd_in;
  logic [15:0]      data_q;
  logic             accept;
  logic             rise_evt, fall_evt, done;
  logic [15:0]      rd_data;
  logic [IDX_W-1:0] bit_idx;
  logic [31:0]      cmd_word;
  logic             unused_bits;

  assign cmd_in.is_wr = bus_wdata[1];
  assign cmd_in.regn  = bus_wdata[8:4];
  assign cmd_in.phy   = bus_wdata[16:12];
  assign accept = bus_we && (bus_addr == A_CMD) && !busy_q && bus_wdata[0];
  assign unused_bits = ^{bus_wdata[31:17], bus_wdata[11:9], bus_wdata[3:2]};

  assign cmd_word = {15'd0, cmd_q.phy, 3'd0, cmd_q.regn, 2'd0, cmd_q.is_wr, busy_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (bus_we && (bus_addr == A_CMD) && !busy_q) begin
        cmd_q <= cmd_in;
        if (bus_wdata[0]) busy_q <= 1'b1;
      end
      if (bus_we && (bus_addr == A_DATA))
        data_q <= bus_wdata[15:0];
      if (done) begin
        busy_q <= 1'b0;
        if (!cmd_q.is_wr) data_q <= rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (bus_addr == A_CMD)       bus_rdata <= cmd_word;
      else if (bus_addr == A_DATA) bus_rdata <= {16'd0, data_q};
      else                         bus_rdata <= '0;
    end
  end

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .en       (busy_q),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame u_frame (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .cmd      (cmd_in),
    .wdata    (data_q),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rd_data  (rd_data),
    .bit_idx  (bit_idx)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input mdio_cmd_t        cmd,
  input logic             mdc,
  input logic             mdio_oe,
  input logic [IDX_W-1:0] bit_idx
);
  localparam int LIMIT = 2 * FRAME_LEN * DIV_HALF;
  localparam int TW = $clog2(LIMIT + 2) + 1;

  logic [TW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
  end

  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe)); // R7

  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mdc != $past(mdc)) |-> $past(busy)); // R7

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(cmd)); // R8

  AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd.is_wr) |-> mdio_oe); // R4

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmd.is_wr && (bit_idx >= IDX_W'(RELEASE_IDX))) |-> !mdio_oe); // R5

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt <= TW'(LIMIT))); // R9
endmodule

bind mdio_mgmt_master mdio_mgmt_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy_q),
  .cmd     (cmd_q),
  .mdc     (mdc),
  .mdio_oe (mdio_oe),
  .bit_idx (bit_idx)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int DIV = 4;
  localparam int AW  = 2;
  localparam int FRAME_CYC = 128 * DIV;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          mdc, mdio_o, mdio_oe;
  logic          mdio_i = 1'b1;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.DIV_HALF(DIV), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and MDC monitor, all sampled at the falling clock edge
  logic        prev_mdc = 1'b0;
  int          rise_cnt = 0;
  int          last_rise = 0;
  int          per_err = 0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  bit          phy_resp = 1'b0;
  logic [15:0] phy_data = '0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mdc && !prev_mdc) begin
      if (rise_cnt > 0 && (cyc - last_rise) != 2 * DIV) per_err++;
      last_rise = cyc;
      cap_bits = {cap_bits[62:0], mdio_o};
      cap_oe   = {cap_oe[62:0], mdio_oe};
      rise_cnt++;
    end
    if (!mdc && prev_mdc) begin
      if ((cyc - last_rise) != DIV) per_err++;
      if (rise_cnt >= 48 && rise_cnt <= 63 && phy_resp)
        mdio_i = phy_data[15 - (rise_cnt - 48)];
      else
        mdio_i = 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cmd_of(input bit wr, input logic [4:0] phy,
                                         input logic [4:0] rg, input bit go);
    return {15'd0, phy, 3'd0, rg, 2'd0, wr, go};
  endfunction

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
  endfunction

  function automatic logic [63:0] exp_oe(input bit wr);
    return wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{47{1'b1}}, 17'd0};
  endfunction

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input bit respond,
                         input logic [15:0] pd, input bit disturb);
    logic [31:0] v;
    int t0;
    int loops;
    bit first_busy;
    logic [63:0] ef, eo;
    if (wr) bus_write(AW'(1), {16'hA5A5, d});
    rise_cnt = 0; cap_bits = '0; cap_oe = '0; per_err = 0;
    phy_resp = respond; phy_data = pd;
    bus_write(AW'(0), cmd_of(wr, phy, rg, 1'b1));
    t0 = cyc;
    if (disturb) begin
      bus_write(AW'(0), cmd_of(!wr, ~phy, ~rg, 1'b1));
      bus_write(AW'(1), {16'd0, ~d});
    end
    loops = 0;
    bus_read(AW'(0), v);
    first_busy = v[0];
    while (v[0] && loops < 4000) begin
      bus_read(AW'(0), v);
      loops++;
    end
    check(first_busy == 1'b1, "R2 busy set after start", 64'(first_busy), 64'd1);
    check(v[0] == 1'b0, "R2 busy clears", 64'(v[0]), 64'd0);
    check(v == cmd_of(wr, phy, rg, 1'b0), disturb ? "R8 fields kept" : "R2 fields readback",
          64'(v), 64'(cmd_of(wr, phy, rg, 1'b0)));
    check((cyc - t0) <= FRAME_CYC + 8 && (cyc - t0) >= FRAME_CYC - 1, "R9 busy duration",
          64'(cyc - t0), 64'(FRAME_CYC));
    check(rise_cnt == 64, "R3 MDC periods per frame", 64'(rise_cnt), 64'd64);
    ef = exp_frame(wr, phy, rg, d);
    eo = exp_oe(wr);
    check((cap_bits & eo) == (ef & eo), wr ? "R4 write frame bits" : "R3 read frame bits",
          cap_bits & eo, ef & eo);
    check(cap_oe == eo, wr ? "R4 drive enable" : "R5 release point", cap_oe, eo);
    check(per_err == 0, "R7 MDC phase lengths", 64'(per_err), 64'd0);
    check(!mdc && !mdio_oe, "R7 idle pins low", 64'({mdc, mdio_oe}), 64'd0);
    if (!wr) begin
      bus_read(AW'(1), v);
      if (respond) check(v == {16'd0, pd}, "R5 read result", 64'(v), 64'(pd));
      else check(v == 32'h0000_FFFF, "R6 absent PHY", 64'(v), 64'hFFFF);
    end
  endtask

  initial begin
    logic [31:0] v;
    int seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!mdc && !mdio_oe, "R1 pins after reset", 64'({mdc, mdio_oe}), 64'd0);
    bus_read(AW'(0), v);
    check(v == 32'd0, "R1 command reset / R10 read", 64'(v), 64'd0);
    bus_read(AW'(1), v);
    check(v == 32'd0, "R1 data reset", 64'(v), 64'd0);
    bus_read(AW'(2), v);
    check(v == 32'd0, "R10 unmapped address", 64'(v), 64'd0);

    // command without start flag: fields only, no frame
    rise_cnt = 0;
    bus_write(AW'(0), cmd_of(1'b1, 5'd9, 5'd3, 1'b0));
    repeat (3 * DIV) @(negedge clk);
    bus_read(AW'(0), v);
    check(v == cmd_of(1'b1, 5'd9, 5'd3, 1'b0), "R2 no-start write", 64'(v),
          64'(cmd_of(1'b1, 5'd9, 5'd3, 1'b0)));
    check(rise_cnt == 0 && !mdc, "R2 no frame without start", 64'(rise_cnt), 64'd0);

    // directed corners
    run_txn(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0, 16'h0, 1'b0);
    run_txn(1'b1, 5'd0, 5'd0, 16'h0000, 1'b0, 16'h0, 1'b0);
    run_txn(1'b0, 5'd1, 5'd2, 16'h0, 1'b1, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd7, 5'd1, 16'h0, 1'b0, 16'h0, 1'b0);       // R6
    run_txn(1'b1, 5'd5, 5'd17, 16'h8001, 1'b0, 16'h0, 1'b1);   // R8, R4
    run_txn(1'b0, 5'd12, 5'd29, 16'h0, 1'b1, 16'hC3A5, 1'b1);  // R8

    // constrained random mix
    for (int i = 0; i < 10; i++) begin
      bit wr;
      logic [31:0] r;
      r  = $urandom();
      wr = r[0];
      run_txn(wr, 5'($urandom()), 5'($urandom()), 16'($urandom()),
              ($urandom() % 4) != 0, 16'($urandom()), 1'b0);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule